// File: doc/BRIEF.md
# Pipelined Barrett Modular Multiplier

This block computes `a·b mod q` for a modulus `q` that may change on every cycle. It serves as the arithmetic core of transform butterflies and of pointwise polynomial products in lattice-based encryption, where each residue channel has its own prime. The caller supplies both operands already reduced below `q`, together with a Barrett ratio precomputed for that modulus. No prime has to be of a special form. Any modulus from 2 up to `2^W − 1` works, including powers of two.

One operation can enter on every clock. Each result leaves after a fixed number of cycles set by the `LATENCY` parameter (default 42), with its valid flag beside it. The three wide products are each built from four narrower partial products over two register stages:

- the full operand product,
- the product of the shifted operand product with the ratio,
- the low part of the quotient estimate times `q`.

Two registered conditional subtractions then bring the remainder into range. A delay line pads the computational pipeline out to the configured latency. The operand width `W` is a parameter, so narrow instances can be swept exhaustively.

Top module: `mm_barrett_mul`

## Requirements
- R1: For `2 ≤ in_q < 2^W`, `in_a < in_q`, `in_b < in_q` and `in_ratio = floor(2^(2k) / in_q)`, where `k` is the bit length of `in_q`, the result equals `(in_a·in_b) mod in_q`. Before correction, the remainder lies below `3·q`.
- R2: `out_valid` rises exactly `LATENCY` (default 42) clock cycles after the cycle in which `in_valid` was sampled high, and `out_res` carries that operation's result.
- R3: An operation may be accepted on every cycle with no stall, and results leave in the order the operations were issued.
- R4: A cycle with `in_valid` low produces a cycle with `out_valid` low `LATENCY` cycles later. A result never appears without an issued operation.
- R5: Reset is synchronous and active low. While `rst_n` is low, operations are dropped, and one cycle after reset `out_valid` is low. Operations in flight at reset never emerge, and `out_res` reads zero after reset until new results arrive.
- R6: Every valid result is strictly less than the modulus that was issued with it.
- R7: The corner operands give the expected values: 0 times anything gives 0, 1 times `b` gives `b`, and `(q−1)·(q−1)` gives 1.
- R8: The result is correct for moduli of every bit length from 20 to `W`, including the power of two `2^(k−1)`, whose ratio is `2^(k+1)`. Consecutive operations may use different moduli.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | W | First operand, below `in_q` |
| in_b | input | W | Second operand, below `in_q` |
| in_q | input | W | Modulus, at least 2 |
| in_ratio | input | W+2 | Barrett ratio `floor(2^(2k)/in_q)` |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | W | `in_a·in_b mod in_q` of the matching operation |

## Verification
The bound checker watches several properties on every cycle:

- the quotient estimate stays within two of the true quotient, seen as the uncorrected remainder staying under three times the modulus;
- the corrected value stays below its modulus;
- reset empties the output;
- valid outputs never outnumber the operations in flight, and never exceed the pipeline depth.

Only the bench's scenarios can show that the numerical result is the exact product modulo `q`, and that the latency is exactly the configured count. The same holds for preserved gaps in a stream, the discarding of in-flight work by a mid-stream reset, and correct behaviour across moduli of every bit length, including powers of two.

// File: rtl/mm_pkg.sv
// Shared constants for the Barrett multiplier.
package mm_pkg;
    // Register stages in the arithmetic core, from input capture to final subtraction.
    parameter int unsigned MM_CORE_STAGES = 12;
    // Register stages inside one split multiplier.
    parameter int unsigned MM_MUL_STAGES = 2;
endpackage

// File: rtl/mm_delay.sv
// Register delay line of configurable depth.
// Assumes DEPTH >= 0; a depth of zero is a plain wire.
module mm_delay #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [WIDTH-1:0] pipe [DEPTH];
            // Shift the data one stage per clock, clearing on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= d;
                    for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign q = pipe[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/mm_split_mul.sv
// Two-stage multiplier built from four half-width partial products.
// Stage 1 registers the partial products, stage 2 registers their aligned sum.
// Only the low OW bits of the product are delivered. Assumes OW <= AW+BW.
// When the high-by-high term lies wholly above bit OW it is not built.
module mm_split_mul #(
    parameter int unsigned AW = 16,
    parameter int unsigned BW = 16,
    parameter int unsigned OW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [OW-1:0] p
);
    localparam int unsigned AL = AW / 2;
    localparam int unsigned AH = AW - AL;
    localparam int unsigned BL = BW / 2;
    localparam int unsigned BH = BW - BL;
    localparam int unsigned SW = AW + BW;

    logic [AL-1:0] a_lo;
    logic [AH-1:0] a_hi;
    logic [BL-1:0] b_lo;
    logic [BH-1:0] b_hi;
    assign a_lo = a[AL-1:0];
    assign a_hi = a[AW-1:AL];
    assign b_lo = b[BL-1:0];
    assign b_hi = b[BW-1:BL];

    logic [AL+BL-1:0] pp_ll;
    logic [AL+BH-1:0] pp_lh;
    logic [AH+BL-1:0] pp_hl;
    logic [SW-1:0]    hh_term;

    // Register the three low-order partial products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_ll <= '0;
            pp_lh <= '0;
            pp_hl <= '0;
        end else begin
            pp_ll <= (AL+BL)'(a_lo) * (AL+BL)'(b_lo);
            pp_lh <= (AL+BH)'(a_lo) * (AL+BH)'(b_hi);
            pp_hl <= (AH+BL)'(a_hi) * (AH+BL)'(b_lo);
        end
    end

    generate
        if ((AL + BL) < OW) begin : g_hh
            logic [AH+BH-1:0] pp_hh;
            // Register the high-by-high partial product.
            always_ff @(posedge clk) begin
                if (!rst_n) pp_hh <= '0;
                else        pp_hh <= (AH+BH)'(a_hi) * (AH+BH)'(b_hi);
            end
            assign hh_term = SW'(pp_hh) << (AL + BL);
        end else begin : g_no_hh
            assign hh_term = '0;
        end
    endgenerate

    logic [SW-1:0] sum;
    assign sum = SW'(pp_ll) + (SW'(pp_lh) << BL) + (SW'(pp_hl) << AL) + hh_term;

    // Register the accumulated product, truncated to the requested width.
    always_ff @(posedge clk) begin
        if (!rst_n) p <= '0;
        else        p <= OW'(sum);
    end
endmodule

// File: rtl/mm_csub.sv
// One registered conditional subtraction: subtracts q once if the value is at least q.
// Assumes the input is below 2^(W+2).
module mm_csub #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W+1:0] r_in,
    input  logic [W-1:0] q,
    output logic [W+1:0] r_out
);
    logic [W+1:0] q_ext;
    assign q_ext = (W+2)'(q);

    // Register the partially corrected remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)             r_out <= '0;
        else if (r_in >= q_ext) r_out <= r_in - q_ext;
        else                    r_out <= r_in;
    end
endmodule

// File: rtl/mm_barrett_mul.sv
// Pipelined modular multiplier, out = a*b mod q, for a runtime modulus.
// Assumes 2 <= q < 2^W, a,b < q, ratio = floor(2^(2k)/q) with k = bit length of q.
// Stages: c1 capture, c2-c3 a*b, c4 shift by k-1, c5-c6 times ratio,
// c7 shift by k+1 (quotient estimate), c8-c9 low part of estimate*q,
// c10 remainder, c11-c12 corrections; a delay line then pads to LATENCY.
module mm_barrett_mul
    import mm_pkg::*;
#(
    parameter int unsigned W       = 64,
    parameter int unsigned LATENCY = 42
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_q,
    input  logic [W+1:0] in_ratio,
    output logic         out_valid,
    output logic [W-1:0] out_res
);
    localparam int unsigned KW  = $clog2(W + 1);
    localparam int unsigned PW  = 2 * W;
    localparam int unsigned XW  = W + 1;
    localparam int unsigned TW  = W + 2;
    localparam int unsigned XTW = XW + TW;
    localparam int unsigned RW  = W + 2;
    localparam int unsigned PAD = LATENCY - MM_CORE_STAGES;

    // Bit length of a value: index of its highest set bit plus one.
    function automatic logic [KW-1:0] bit_len(input logic [W-1:0] v);
        logic [KW-1:0] n;
        n = '0;
        for (int i = 0; i < W; i++) if (v[i]) n = KW'(i + 1);
        return n;
    endfunction

    logic          s1_v;
    logic [W-1:0]  s1_a, s1_b, s1_q;
    logic [TW-1:0] s1_t;

    // c1: capture the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s1_a <= '0;
            s1_b <= '0;
            s1_q <= '0;
            s1_t <= '0;
        end else begin
            s1_v <= in_valid;
            s1_a <= in_a;
            s1_b <= in_b;
            s1_q <= in_q;
            s1_t <= in_ratio;
        end
    end

    logic [KW-1:0] s2_k, s3_k, s6_k;

    // c2: bit length of the modulus.
    always_ff @(posedge clk) begin
        if (!rst_n) s2_k <= '0;
        else        s2_k <= bit_len(s1_q);
    end

    mm_delay #(.WIDTH(KW), .DEPTH(1)) u_dly_k3 (.clk(clk), .rst_n(rst_n), .d(s2_k), .q(s3_k));
    mm_delay #(.WIDTH(KW), .DEPTH(3)) u_dly_k6 (.clk(clk), .rst_n(rst_n), .d(s3_k), .q(s6_k));

    // c2-c3: full operand product.
    logic [PW-1:0] s3_p;
    mm_split_mul #(.AW(W), .BW(W), .OW(PW)) u_mul_ab (
        .clk(clk), .rst_n(rst_n), .a(s1_a), .b(s1_b), .p(s3_p)
    );

    logic [XW-1:0] s4_x;
    // c4: drop the low k-1 bits of the product.
    always_ff @(posedge clk) begin
        if (!rst_n) s4_x <= '0;
        else        s4_x <= XW'(s3_p >> (s3_k - KW'(1)));
    end

    logic [TW-1:0] s4_t;
    mm_delay #(.WIDTH(TW), .DEPTH(3)) u_dly_t4 (.clk(clk), .rst_n(rst_n), .d(s1_t), .q(s4_t));

    logic [RW-1:0] s9_plow;
    mm_delay #(.WIDTH(RW), .DEPTH(6)) u_dly_p9 (
        .clk(clk), .rst_n(rst_n), .d(s3_p[RW-1:0]), .q(s9_plow)
    );

    // c5-c6: shifted product times the ratio.
    logic [XTW-1:0] s6_xt;
    mm_split_mul #(.AW(XW), .BW(TW), .OW(XTW)) u_mul_xt (
        .clk(clk), .rst_n(rst_n), .a(s4_x), .b(s4_t), .p(s6_xt)
    );

    logic [W-1:0] s7_qe;
    // c7: quotient estimate, dropping k+1 low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) s7_qe <= '0;
        else        s7_qe <= W'(s6_xt >> ((KW+1)'(s6_k) + (KW+1)'(1)));
    end

    logic [W-1:0] s7_q, s10_q, s11_q;
    mm_delay #(.WIDTH(W), .DEPTH(6)) u_dly_q7  (.clk(clk), .rst_n(rst_n), .d(s1_q),  .q(s7_q));
    mm_delay #(.WIDTH(W), .DEPTH(3)) u_dly_q10 (.clk(clk), .rst_n(rst_n), .d(s7_q),  .q(s10_q));
    mm_delay #(.WIDTH(W), .DEPTH(1)) u_dly_q11 (.clk(clk), .rst_n(rst_n), .d(s10_q), .q(s11_q));

    // c8-c9: low bits of estimate times modulus.
    logic [RW-1:0] s9_qq;
    mm_split_mul #(.AW(W), .BW(W), .OW(RW)) u_mul_qq (
        .clk(clk), .rst_n(rst_n), .a(s7_qe), .b(s7_q), .p(s9_qq)
    );

    logic [RW-1:0] s10_r;
    // c10: uncorrected remainder, exact modulo 2^(W+2).
    always_ff @(posedge clk) begin
        if (!rst_n) s10_r <= '0;
        else        s10_r <= s9_plow - s9_qq;
    end

    logic [RW-1:0] s11_r, s12_r;
    mm_csub #(.W(W)) u_sub_a (.clk(clk), .rst_n(rst_n), .r_in(s10_r), .q(s10_q), .r_out(s11_r));
    mm_csub #(.W(W)) u_sub_b (.clk(clk), .rst_n(rst_n), .r_in(s11_r), .q(s11_q), .r_out(s12_r));

    logic s10_v, s11_v, s12_v;
    mm_delay #(.WIDTH(1), .DEPTH(9)) u_dly_v10 (.clk(clk), .rst_n(rst_n), .d(s1_v),  .q(s10_v));
    mm_delay #(.WIDTH(1), .DEPTH(1)) u_dly_v11 (.clk(clk), .rst_n(rst_n), .d(s10_v), .q(s11_v));
    mm_delay #(.WIDTH(1), .DEPTH(1)) u_dly_v12 (.clk(clk), .rst_n(rst_n), .d(s11_v), .q(s12_v));

    // Pad the core out to the configured latency.
    logic [W:0] pad_out;
    mm_delay #(.WIDTH(W + 1), .DEPTH(PAD)) u_pad (
        .clk(clk), .rst_n(rst_n), .d({s12_v, s12_r[W-1:0]}), .q(pad_out)
    );
    assign out_valid = pad_out[W];
    assign out_res   = pad_out[W-1:0];
endmodule

// File: rtl/mm_barrett_mul_chk.sv
// Checker bound to mm_barrett_mul: range of intermediate remainders, reset,
// and occupancy of the pipeline.
module mm_barrett_mul_chk #(
    parameter int unsigned W       = 64,
    parameter int unsigned LATENCY = 42
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic         v_c10,
    input logic [W+1:0] r_c10,
    input logic [W-1:0] q_c10,
    input logic         v_c11,
    input logic [W-1:0] q_c11,
    input logic [W+1:0] res_c12
);
    logic [15:0] inflight;

    // Count operations accepted but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + 16'(in_valid) - 16'(out_valid);
    end

    // R1: the quotient estimate is short by at most two multiples of q.
    p_qest_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        v_c10 |-> (r_c10 < (W+2)'(q_c10) * (W+2)'(3)));

    // R6: after both corrections the value lies below its modulus.
    p_final_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        v_c11 |=> (res_c12 < (W+2)'($past(q_c11))));

    // R5: reset empties the output one cycle later.
    p_reset_clears_r5: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R4: a result needs an operation in flight.
    p_out_has_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != 16'd0));

    // R3: occupancy never exceeds the pipeline depth.
    p_inflight_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 16'(LATENCY));
endmodule

bind mm_barrett_mul mm_barrett_mul_chk #(.W(W), .LATENCY(LATENCY)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .v_c10(s10_v), .r_c10(s10_r), .q_c10(s10_q),
    .v_c11(s11_v), .q_c11(s11_q), .res_c12(s12_r)
);

// File: tb/mm_barrett_mul_bench.sv
`timescale 1ns/1ps
module mm_barrett_mul_bench;
    localparam int W   = 64;
    localparam int LAT = 42;
    localparam int NV  = 10;
    localparam int QN  = 2048;

    // Directed vectors: modulus, a, b, expected.
    localparam logic [63:0] VEC [NV][4] = '{
        '{64'd97, 64'd50, 64'd60, 64'd90},
        '{64'd97, 64'd96, 64'd96, 64'd1},
        '{64'd97, 64'd0, 64'd55, 64'd0},
        '{64'd97, 64'd1, 64'd42, 64'd42},
        '{64'h1FFFFFFFFFFFFFFF, 64'h1FFFFFFFFFFFFFFE, 64'h1FFFFFFFFFFFFFFE, 64'd1},
        '{64'h1FFFFFFFFFFFFFFF, 64'h1000000000000000, 64'd2, 64'd1},
        '{64'hFFFFFFFF00000001, 64'hFFFFFFFF00000000, 64'd2, 64'hFFFFFFFEFFFFFFFF},
        '{64'd1048583, 64'd1048576, 64'd1048576, 64'd49},
        '{64'd1024, 64'd1000, 64'd3, 64'd952},
        '{64'd2, 64'd1, 64'd1, 64'd1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0, in_q = '0;
    logic [W+1:0] in_ratio = '0;
    logic         out_valid;
    logic [W-1:0] out_res;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wr = 0, rd = 0;
    logic [W-1:0] exp_res [QN];
    int           exp_cyc [QN];
    string        exp_tag [QN];
    string        idle_tag = "R4";
    bit           done = 1'b0;

    always #2 clk = ~clk;

    mm_barrett_mul #(.W(W), .LATENCY(LAT)) u_mm_barrett_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_q(in_q), .in_ratio(in_ratio), .out_valid(out_valid), .out_res(out_res)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int bitlen(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n = i + 1;
        return n;
    endfunction

    function automatic logic [W+1:0] ratio_of(input logic [W-1:0] q);
        logic [2*W+1:0] num;
        num = (2*W+2)'(1) << (2 * bitlen(q));
        return (W+2)'(num / (2*W+2)'(q));
    endfunction

    function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, b, q);
        return W'(((2*W)'(a) * (2*W)'(b)) % (2*W)'(q));
    endfunction

    function automatic logic [W-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Drive one operation on the current low phase, then wait a cycle.
    task automatic issue(input logic [W-1:0] q, a, b, exp_v, input string tag);
        in_valid = 1'b1; in_q = q; in_a = a; in_b = b; in_ratio = ratio_of(q);
        exp_res[wr] = exp_v; exp_cyc[wr] = cyc; exp_tag[wr] = tag;
        wr++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Output monitor: order, value and latency of each result.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && out_valid) begin
            if (rd == wr) begin
                check(1'b0, idle_tag, out_res, '0);
            end else begin
                check(out_res == exp_res[rd], exp_tag[rd], out_res, exp_res[rd]);
                check(cyc - exp_cyc[rd] == LAT, "R2 latency", W'(cyc - exp_cyc[rd]), W'(LAT));
                rd++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int nvalid;
        logic [W-1:0] q, a, b;
        repeat (3) @(negedge clk);
        // R5: reset state of the outputs.
        check(out_valid == 1'b0, "R5 reset valid", W'(out_valid), '0);
        check(out_res == '0, "R5 reset result", out_res, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R7: table of directed vectors, issued back to back (R3).
        for (int i = 0; i < NV; i++)
            issue(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], "R1 table");
        idle(LAT + 4);

        // R8 / R7: every bit length, random modulus and power of two, corners and random.
        for (int w = 20; w <= W; w++) begin
            q = rnd64() & ((W'(1) << (w - 1)) - W'(1) | (W'(1) << (w - 1)));
            q = q | (W'(1) << (w - 1)) | W'(1);
            issue(q, '0, q - 1, '0, "R7 zero");
            issue(q, W'(1), q - 2, q - 2, "R7 one");
            issue(q, q - 1, q - 1, W'(1), "R7 q-1 squared");
            a = rnd64() % q; b = rnd64() % q;
            issue(q, a, b, ref_mul(a, b, q), "R8 random");
            q = W'(1) << (w - 1);
            a = rnd64() % q; b = rnd64() % q;
            issue(q, a, b, ref_mul(a, b, q), "R8 power of two");
        end
        idle(LAT + 4);

        // R4: bursts separated by gaps of varying length.
        for (int g = 0; g < 12; g++) begin
            q = rnd64() | (W'(1) << (W - 1));
            a = rnd64() % q; b = rnd64() % q;
            issue(q, a, b, ref_mul(a, b, q), "R4 gapped");
            idle(g % 4);
        end
        idle(LAT + 4);

        // R5: reset while operations are in flight; none may emerge.
        for (int i = 0; i < 10; i++) begin
            q = rnd64() | W'(3);
            a = rnd64() % q; b = rnd64() % q;
            issue(q, a, b, ref_mul(a, b, q), "R5 dropped");
        end
        rst_n = 1'b0;
        @(negedge clk);
        rd = wr;
        idle_tag = "R5 flushed op emerged";
        check(out_valid == 1'b0, "R5 valid after reset", W'(out_valid), '0);
        rst_n = 1'b1;
        nvalid = 0;
        for (int i = 0; i < LAT + 6; i++) begin
            if (out_valid) nvalid++;
            @(negedge clk);
        end
        check(nvalid == 0, "R5 no output after flush", W'(nvalid), '0);
        idle_tag = "R4";

        // R3: long back-to-back stream with a new modulus each cycle.
        for (int i = 0; i < 120; i++) begin
            q = (rnd64() >> (i % 45)) | (W'(1) << 19) | W'(1);
            a = rnd64() % q; b = rnd64() % q;
            issue(q, a, b, ref_mul(a, b, q), "R3 stream");
        end
        idle(LAT + 4);

        check(rd == wr, "R3 all results delivered", W'(rd), W'(wr));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule